// File: doc/BRIEF.md
# Fractional-Divisor Low-Power Serial Transmitter

This block sends bytes as asynchronous serial frames (one start bit, eight data bits sent least significant first, one stop bit). It runs entirely from a slow kernel clock, typically a 32.768 kHz crystal, and it takes no faster clock to time its bits. The bit rate comes from a divisor input that carries eight fractional bits. On every kernel cycle a phase accumulator gains 256. When the sum reaches the divisor, the divisor is subtracted and a bit boundary is produced. The leftover residue is kept, so the rate is 256 × f_kernel ÷ divisor on average.

Every bit edge lands on a kernel clock edge, so single bits are uneven. Each bit lasts either the floor or the ceiling of divisor/256 kernel cycles. Because the residue carries forward, frame and long-run timing do not drift. At 9600 baud from 32.768 kHz the divisor is 874 and bits are 3 or 4 kernel cycles long. Bytes enter through a valid/ready handshake. A byte may also be queued during the stop bit, so frames follow each other with no idle gap.

Top module: `fracbaud_tx`

## Requirements
- R1: After reset the serial line is high and busy is low.
- R2: Within a chain of back-to-back frames, the k-th bit boundary falls exactly ceil(k × D / 256) kernel cycles after the edge that accepted the chain's first byte (D = divisor). The accumulator starts from zero when a chain starts from idle.
- R3: Every bit, start and stop bits included, lasts floor(D/256) or ceil(D/256) kernel cycles.
- R4: Frame format: line high when idle, start bit low, then data bit 0 up to data bit 7, then a high stop bit.
- R5: txReady is high only when enable is high, D ≥ 768, and the block is either idle or in its stop bit with no byte already queued. A byte is taken on a rising edge where txValid and txReady are both high.
- R6: With D below 768, txReady stays low, the line stays high and no frame starts.
- R7: With enable low, txReady stays low and no new frame starts.
- R8: A byte accepted during a stop bit starts its start bit in the very cycle the stop bit ends, so n chained frames last exactly ceil(10·n·D/256) cycles.
- R9: busy goes high on the accepting edge and stays high until the stop bit of the last queued frame ends.
- R10: At D = 874 every bit lasts 3 or 4 cycles and a lone frame keeps busy high for 35 cycles. At D = 768 every bit lasts exactly 3 cycles and a frame lasts 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| divisor | input | DIV_W (16) | Bit period in kernel cycles × 256; must stay stable while busy |
| txData | input | DATA_W (8) | Byte to send |
| txValid | input | 1 | txData holds a byte |
| txReady | output | 1 | Block takes the byte this cycle if txValid is high |
| txLine | output | 1 | Serial output, idle high |
| busy | output | 1 | A frame is in progress |

## Verification
The bench sends alternating-bit bytes back to back, so that every bit boundary shows as a line edge. It measures each width and the running total against the ideal time. A design that cleared the residue at each bit would give fixed-length bits and drift within a frame. One that cleared it between chained frames would break the cumulative bound. A gap between chained frames shows as a stretched stop bit and a longer chain.
The divisor is pushed to 768, where bits must be exactly three cycles, and to 767, where nothing may start. An off-by-one in the legality compare either refuses the lowest legal value or sends at the illegal one. Queuing during the stop bit while another byte is already held, lowering enable, and chains started from idle catch a ready flag that is open too long or an accumulator left dirty.

// File: rtl/fracbaud_pkg.sv
`timescale 1ns/1ps
package fracbaud_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } txPhase_t;

  // strobes from control to datapath; at most one line action per cycle
  typedef struct packed {
    logic loadByte;   // capture txData into the shifter
    logic driveLow;   // begin a start bit
    logic shiftBit;   // put shifter LSB on the line and shift
    logic driveHigh;  // begin stop bit or return to idle
  } lineCmd_t;

endpackage

// File: rtl/fracbaud_acc.sv
`timescale 1ns/1ps
module fracbaud_acc #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             clear,
  input  logic [DIV_W-1:0] divisor,
  output logic             bitTick
);
  localparam int ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] sumW;
  logic [ACC_W-1:0] divW;

  assign divW    = {1'b0, divisor};
  assign sumW    = accQ + STEP;
  assign bitTick = run && (sumW >= divW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (clear) begin
      accQ <= '0;
    end else if (run) begin
      accQ <= bitTick ? (sumW - divW) : sumW;
    end
  end

  // cycles since the last boundary, for the width check
  logic [DIV_W-1:0] gapQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapQ <= '0;
    end else if (clear || bitTick) begin
      gapQ <= '0;
    end else if (run) begin
      gapQ <= gapQ + DIV_W'(1);
    end
  end

  // R3: each bit lasts floor or ceil of divisor/256 cycles
  a_r3_bit_width: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> (((gapQ + DIV_W'(1)) == (divisor >> FRAC_W)) ||
                 ((gapQ + DIV_W'(1)) == ((divisor >> FRAC_W) + DIV_W'(1)))));

  // R2: the residue never reaches the divisor, so no boundary is skipped
  a_r2_residue_bound: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (accQ < divW));

endmodule

// File: rtl/fracbaud_ctrl.sv
`timescale 1ns/1ps
module fracbaud_ctrl
  import fracbaud_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divisor,
  input  logic             txValid,
  input  logic             bitTick,
  output logic             txReady,
  output logic             busy,
  output logic             run,
  output logic             clearAcc,
  output lineCmd_t         cmd
);
  localparam int MIN_DIV = 3 << FRAC_W;
  localparam int CNT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  txPhase_t        phaseQ, phaseD;
  logic [CNT_W-1:0] idxQ, idxD;
  logic            pendQ, pendD;
  logic            divOk, canTake, accept;

  assign divOk   = (divisor >= DIV_W'(MIN_DIV));
  assign canTake = enable && divOk;
  assign txReady = canTake && ((phaseQ == PH_IDLE) || ((phaseQ == PH_STOP) && !pendQ));
  assign accept  = txValid && txReady;
  assign run     = (phaseQ != PH_IDLE);
  assign busy    = run;

  always_comb begin
    phaseD   = phaseQ;
    idxD     = idxQ;
    pendD    = pendQ;
    cmd      = '0;
    clearAcc = 1'b0;
    unique case (phaseQ)
      PH_IDLE: begin
        if (accept) begin
          cmd.loadByte = 1'b1;
          cmd.driveLow = 1'b1;
          clearAcc     = 1'b1;
          phaseD       = PH_START;
        end
      end
      PH_START: begin
        if (bitTick) begin
          cmd.shiftBit = 1'b1;
          idxD         = '0;
          phaseD       = PH_DATA;
        end
      end
      PH_DATA: begin
        if (bitTick) begin
          if (idxQ == LAST_IDX) begin
            cmd.driveHigh = 1'b1;
            phaseD        = PH_STOP;
          end else begin
            cmd.shiftBit = 1'b1;
            idxD         = idxQ + CNT_W'(1);
          end
        end
      end
      PH_STOP: begin
        if (accept) begin
          cmd.loadByte = 1'b1;
          pendD        = 1'b1;
        end
        if (bitTick) begin
          if (pendQ || accept) begin
            cmd.driveLow = 1'b1;
            pendD        = 1'b0;
            phaseD       = PH_START;
          end else begin
            cmd.driveHigh = 1'b1;
            phaseD        = PH_IDLE;
          end
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      idxQ   <= '0;
      pendQ  <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      idxQ   <= idxD;
      pendQ  <= pendD;
    end
  end

  // R9: an accepted byte from idle makes the block busy in its start bit
  a_r9_busy_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_IDLE && txValid && txReady) |=> (busy && phaseQ == PH_START));

  // R8: a queued byte follows the stop bit with no idle cycle
  a_r8_chain_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_STOP && bitTick && pendQ) |=> (phaseQ == PH_START));

  // R4: after the last data bit the frame moves to its stop bit
  a_r4_stop_follows_data: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_DATA && bitTick && idxQ == LAST_IDX) |=> (phaseQ == PH_STOP));

  // R5: no byte is taken while start or data bits are on the line
  a_r5_closed_mid_frame: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_START || phaseQ == PH_DATA) |-> !txReady);

  // R6: an illegal divisor never lets a frame begin
  a_r6_illegal_divisor: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_IDLE && !divOk) |=> (phaseQ == PH_IDLE));

endmodule

// File: rtl/fracbaud_dp.sv
`timescale 1ns/1ps
module fracbaud_dp
  import fracbaud_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineCmd_t          cmd,
  input  logic [DATA_W-1:0] txData,
  output logic              txLine
);
  logic [DATA_W-1:0] shiftQ;
  logic              lineQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (cmd.loadByte) begin
      shiftQ <= txData;
    end else if (cmd.shiftBit) begin
      shiftQ <= shiftQ >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ <= 1'b1;
    end else if (cmd.driveLow) begin
      lineQ <= 1'b0;
    end else if (cmd.shiftBit) begin
      lineQ <= shiftQ[0];
    end else if (cmd.driveHigh) begin
      lineQ <= 1'b1;
    end
  end

  assign txLine = lineQ;

  // R4: the start strobe puts a low level on the line in the next cycle
  a_r4_start_level: assert property (@(posedge clk) disable iff (!rstN)
    cmd.driveLow |=> !txLine);

  // R4: data go out LSB first from the byte that was captured
  a_r4_lsb_first: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.shiftBit && !cmd.loadByte) |=> (txLine == $past(shiftQ[0])));

endmodule

// File: rtl/fracbaud_tx.sv
`timescale 1ns/1ps
module fracbaud_tx
  import fracbaud_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              txLine,
  output logic              busy
);
  lineCmd_t cmd;
  logic     bitTick;
  logic     run;
  logic     clearAcc;

  fracbaud_acc #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_acc (
    .clk     (clk),
    .rstN    (rstN),
    .run     (run),
    .clear   (clearAcc),
    .divisor (divisor),
    .bitTick (bitTick)
  );

  fracbaud_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .divisor  (divisor),
    .txValid  (txValid),
    .bitTick  (bitTick),
    .txReady  (txReady),
    .busy     (busy),
    .run      (run),
    .clearAcc (clearAcc),
    .cmd      (cmd)
  );

  fracbaud_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .txData (txData),
    .txLine (txLine)
  );

  // R1: the line rests high whenever no frame is in progress
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  // R4: every frame opens with a low start bit
  a_r4_opens_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txLine);

  // R9: busy only ends after a high stop bit
  a_r9_ends_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(txLine));

endmodule

// File: tb/sim_fracbaud_tx.sv
`timescale 1ns/1ps
module sim_fracbaud_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] divisor = 16'd874;
  logic [7:0]  txData = 8'h00;
  logic        txValid = 1'b0;
  logic        txReady, txLine, busy;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fracbaud_tx u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .divisor(divisor),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .txLine(txLine), .busy(busy)
  );

  // behavioural reference: boundaries at ceil(k*D/256) after chain start
  bit      mActive = 0, mPend = 0;
  longint  mCyc = 0;
  longint  mK = 0;
  int      mPos = 0;
  logic [7:0] mByte = 0, mPendByte = 0;
  bit      checkOn = 0, lastAcc = 0;
  longint  gCyc = 0;
  int      busyCnt = 0;
  logic [7:0] rxSh = 0;
  int      prevPos = -1;
  // edge measurement for alternating-bit chains
  bit      measOn = 0;
  longint  firstEdge = 0, lastEdge = 0;
  longint  edgeIdx = -1;
  logic    prevLine = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit expReady();
    return enable && (divisor >= 16'd768) && (!mActive || (mPos == 9 && !mPend));
  endfunction

  function automatic logic expLine();
    if (!mActive) return 1'b1;
    if (mPos == 0) return 1'b0;
    if (mPos == 9) return 1'b1;
    return mByte[mPos-1];
  endfunction

  task automatic stepModel(input bit acc, input logic [7:0] d);
    if (!mActive) begin
      if (acc) begin
        mActive = 1; mCyc = 0; mK = 0; mPos = 0; mByte = d; mPend = 0;
      end
    end else begin
      if (acc) begin mPend = 1; mPendByte = d; end
      mCyc++;
      if (mCyc * 256 >= (mK + 1) * longint'(divisor)) begin
        mK++;
        if (mPos == 9) begin
          if (mPend) begin mPos = 0; mByte = mPendByte; mPend = 0; end
          else mActive = 0;
        end else mPos++;
      end
    end
  endtask

  task automatic tick();
    bit accNow;
    logic [7:0] dNow;
    longint w, el, diff, fl;
    #1;
    accNow = txValid && expReady();
    dNow = txData;
    if (checkOn) check(txReady == expReady(), "R5", "ready", txReady, expReady());
    @(negedge clk);
    gCyc++;
    lastAcc = accNow;
    if (!checkOn) return;
    stepModel(accNow, dNow);
    check(txLine == expLine(), "R2", "line level", txLine, expLine());
    check(busy == mActive, "R9", "busy", busy, mActive);
    if (busy) busyCnt++;
    if (mActive && mPos >= 1 && mPos <= 8) rxSh[mPos-1] = txLine;
    if (mActive && mPos == 9 && prevPos == 8)
      check(rxSh == mByte, "R4", "decoded byte", rxSh, mByte);
    prevPos = mActive ? mPos : -1;
    if (measOn && txLine != prevLine) begin
      if (edgeIdx < 0) begin
        firstEdge = gCyc; edgeIdx = 0;
      end else begin
        w = gCyc - lastEdge;
        fl = longint'(divisor) / 256;
        edgeIdx++;
        check(w == fl || (divisor % 256 != 0 && w == fl + 1), "R3", "bit width", w, fl);
        el = gCyc - firstEdge;
        diff = el * 256 - edgeIdx * longint'(divisor);
        check(diff >= 0 && diff < 256, "R2", "cumulative time x256 minus ideal", diff, 0);
      end
      lastEdge = gCyc;
    end
    prevLine = txLine;
  endtask

  task automatic sendByte(input logic [7:0] b);
    txValid = 1'b1;
    txData = b;
    do tick(); while (!lastAcc);
    txValid = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    tick();
    while (busy && n < 5000) begin tick(); n++; end
  endtask

  task automatic measureChain(input logic [15:0] d, input int n, input string req);
    longint expLen;
    divisor = d;
    tick();
    measOn = 1; edgeIdx = -1; prevLine = txLine; busyCnt = 0;
    for (int i = 0; i < n; i++) sendByte(8'h55);
    waitIdle();
    measOn = 0;
    expLen = (longint'(10 * n) * d + 255) / 256;
    check(busyCnt == expLen, req, "chain busy cycles", busyCnt, expLen);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    checkOn = 1;
    tick();
    // R1 reset state
    check(txLine == 1'b1, "R1", "line after reset", txLine, 1);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    enable = 1'b1;

    // R10 lone frame at the 9600-from-32768 point
    divisor = 16'd874;
    tick();
    busyCnt = 0;
    sendByte(8'hA3);
    waitIdle();
    check(busyCnt == 35, "R10", "frame length at 874", busyCnt, 35);

    // R3 R2 R8 chained alternating frames at 874
    measureChain(16'd874, 4, "R8");

    // R10 exact three-cycle bits at 768
    divisor = 16'd768;
    tick();
    busyCnt = 0;
    sendByte(8'h3C);
    waitIdle();
    check(busyCnt == 30, "R10", "frame length at 768", busyCnt, 30);
    measureChain(16'd768, 2, "R10");

    // R4 assorted bytes, chained, at a slow divisor
    divisor = 16'd1000;
    tick();
    sendByte(8'h00); sendByte(8'hFF); sendByte(8'h81); sendByte(8'h7E); sendByte(8'h01);
    waitIdle();

    // R8 longer chain with an odd divisor
    measureChain(16'd2085, 5, "R8");

    // R6 illegal divisor
    divisor = 16'd767;
    txValid = 1'b1; txData = 8'h5A;
    for (int i = 0; i < 20; i++) begin
      tick();
      check(txLine == 1'b1 && busy == 1'b0, "R6", "line/busy with divisor 767", {txLine, busy}, 2);
    end
    check(txReady == 1'b0, "R6", "ready with divisor 767", txReady, 0);
    txValid = 1'b0;

    // R7 enable low
    divisor = 16'd874;
    enable = 1'b0;
    txValid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      check(busy == 1'b0 && txLine == 1'b1, "R7", "busy/line with enable low", {txLine, busy}, 2);
    end
    check(txReady == 1'b0, "R7", "ready with enable low", txReady, 0);
    txValid = 1'b0;
    enable = 1'b1;

    // R2 fresh chain from idle after a pause starts with a cleared accumulator
    repeat (7) tick();
    busyCnt = 0;
    sendByte(8'hC5);
    waitIdle();
    check(busyCnt == 35, "R2", "frame length after idle", busyCnt, 35);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule